// File: doc/BRIEF.md
# Rate-Based Victim Way Selector

This block chooses which way of a 4-way set-associative cache is overwritten when a miss needs room. It does not track recency. Each way keeps a local count of the accesses that reached it. Each set keeps one global count of all accesses to the set. A way's estimated reference rate is its local count over the set's global count. On a miss, the way with the lowest estimate becomes the victim. Because all ways of a set share the same denominator, the block compares the local counts directly and needs no divider.

The cache controller presents a set index together with either a hit (and the way that hit) or a miss request. A hit advances the hit way's local count and the set's global count. A miss names a victim one cycle later with a single-cycle strobe. The same miss also counts as a fill of that way: the way becomes valid, its local count restarts from zero, and the global count advances. Empty ways are always used before a valid way is evicted. When several valid ways share the lowest count, a free-running 16-bit LFSR picks one of them.

Tag storage, data arrays and the memory fetch stay with the surrounding cache.

Top module: `rate_victim_select`

## Requirements
- R1: While reset is high and in the cycle after it, `victim_valid_o` is 0. After reset, every way of every set is empty and all counts are zero.
- R2: A miss to a set that holds an empty way names the lowest-numbered empty way. Four misses to a set fresh from reset therefore name ways 0, 1, 2 and 3 in that order.
- R3: A miss (`miss_i`=1 with `hit_i`=0) sampled at a clock edge drives `victim_valid_o` to 1, with the victim on `victim_way_o`, right after that edge. The strobe lasts one cycle unless another miss follows.
- R4: When all ways of the set are valid, the victim is a way whose local count is the smallest in that set.
- R5: When several valid ways share the smallest count, the victim is one of them. Over repeated ties, more than one way gets chosen.
- R6: The victim way's local count restarts at 0 on the miss that names it. The fill still advances the set's global count by one.
- R7: A hit adds one to the hit way's local count and to its set's global count. No other set changes, and a way's local count never exceeds its set's global count.
- R8: Counts are CNT_W bits wide. When an access reaches a set whose global count is at its all-ones maximum, every count of that set is first halved (floor), and then the access is applied.
- R9: When `hit_i` and `miss_i` are both 1, the hit is applied, the miss is ignored, and no victim strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | SET_W | Set addressed by this cycle's hit or miss |
| hit_i | input | 1 | A hit to `hit_way_i` of `set_i` |
| hit_way_i | input | 2 | Way that hit |
| miss_i | input | 1 | Miss request for `set_i` |
| victim_valid_o | output | 1 | One-cycle strobe: `victim_way_o` holds a new victim |
| victim_way_o | output | 2 | Chosen victim way |

## Verification
The bench builds the block with NUM_SETS=4 and CNT_W=4. With counts only four bits wide, a set's global count reaches its maximum of 15 after a handful of accesses. The halve-then-apply path therefore runs many times, both in the directed sequences and under random traffic. Four sets are enough to show that hits in one set leave the choice in another unchanged. Because the LFSR is never modelled, ties are checked for membership in the minimum set and for spread across ways.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WAYS-1:0]  wmask_t;
    typedef logic [WAY_W:0]   wcnt_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        way_t way;
    } upd_t;

    function automatic way_t lowest_set(input wmask_t m);
        way_t r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (m[i]) r = way_t'(i);
        end
        return r;
    endfunction

    function automatic wcnt_t ones(input wmask_t m);
        wcnt_t n;
        n = '0;
        for (int i = 0; i < WAYS; i++) begin
            n = n + wcnt_t'(m[i]);
        end
        return n;
    endfunction

    function automatic way_t nth_set(input wmask_t m, input wcnt_t k);
        way_t  r;
        wcnt_t seen;
        r    = '0;
        seen = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (m[i]) begin
                if (seen == k) r = way_t'(i);
                seen = seen + 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rvs_lfsr.sv
module rvs_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] rnd_o
);
    logic [15:0] st_q;
    logic        fb;

    assign fb    = st_q[15] ^ st_q[13] ^ st_q[12] ^ st_q[10];
    assign rnd_o = st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= SEED;
        else     st_q <= {st_q[14:0], fb};
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        st_q != 16'h0000); // R5
endmodule

// File: rtl/rvs_set_store.sv
module rvs_set_store
    import rvs_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int CNT_W    = 8,
    parameter int SET_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SET_W-1:0]             set_i,
    input  upd_t                         upd_i,
    output wmask_t                       rd_valid_o,
    output logic [WAYS-1:0][CNT_W-1:0]   rd_local_o,
    output logic [CNT_W-1:0]             rd_glob_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WAYS-1:0][CNT_W-1:0] loc_q [NUM_SETS];
    wmask_t                     val_q [NUM_SETS];
    logic [CNT_W-1:0]           glb_q [NUM_SETS];

    logic                       halve;
    logic [WAYS-1:0][CNT_W-1:0] base_loc;
    logic [CNT_W-1:0]           base_glb;
    logic [WAYS-1:0][CNT_W-1:0] nxt_loc;
    logic [CNT_W-1:0]           nxt_glb;
    wmask_t                     nxt_val;

    assign rd_valid_o = val_q[set_i];
    assign rd_local_o = loc_q[set_i];
    assign rd_glob_o  = glb_q[set_i];

    assign halve    = (rd_glob_o == CNT_MAX);
    assign base_glb = halve ? (rd_glob_o >> 1) : rd_glob_o;
    assign nxt_glb  = base_glb + 1'b1;

    always_comb begin
        nxt_val = rd_valid_o;
        for (int w = 0; w < WAYS; w++) begin
            base_loc[w] = halve ? (rd_local_o[w] >> 1) : rd_local_o[w];
            nxt_loc[w]  = base_loc[w];
            if (upd_i.way == way_t'(w)) begin
                if (upd_i.op == OP_HIT) begin
                    nxt_loc[w] = (base_loc[w] == CNT_MAX) ? base_loc[w]
                                                          : base_loc[w] + 1'b1;
                end else if (upd_i.op == OP_FILL) begin
                    nxt_loc[w] = '0;
                    nxt_val[w] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                loc_q[s] <= '0;
                val_q[s] <= '0;
                glb_q[s] <= '0;
            end
        end else if (upd_i.op != OP_IDLE) begin
            loc_q[set_i] <= nxt_loc;
            val_q[set_i] <= nxt_val;
            glb_q[set_i] <= nxt_glb;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_bound
        AST_LOCAL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
            rd_local_o[w] <= rd_glob_o); // R7
    end
endmodule

// File: rtl/rvs_pick.sv
module rvs_pick
    import rvs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  wmask_t                     valid_i,
    input  logic [WAYS-1:0][CNT_W-1:0] local_i,
    input  logic [7:0]                 rnd_i,
    output way_t                       pick_o,
    output wmask_t                     tie_o
);
    logic [CNT_W-1:0] minv;
    wmask_t           empty;
    wcnt_t            n_tie;
    logic [7:0]       kk;

    assign empty = ~valid_i;

    always_comb begin
        minv = local_i[0];
        for (int w = 1; w < WAYS; w++) begin
            if (local_i[w] < minv) minv = local_i[w];
        end
        for (int w = 0; w < WAYS; w++) begin
            tie_o[w] = (local_i[w] == minv);
        end
        n_tie = ones(tie_o);
        kk    = (n_tie == '0) ? 8'd0 : (rnd_i % 8'(n_tie));
        if (|empty) pick_o = lowest_set(empty);
        else        pick_o = nth_set(tie_o, kk[WAY_W:0]);
    end
endmodule

// File: rtl/rate_victim_select.sv
module rate_victim_select
    import rvs_pkg::*;
#(
    parameter int          NUM_SETS = 16,
    parameter int          CNT_W    = 8,
    parameter logic [15:0] SEED     = 16'hACE1,
    localparam int         SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic             hit_i,
    input  logic [1:0]       hit_way_i,
    input  logic             miss_i,
    output logic             victim_valid_o,
    output logic [1:0]       victim_way_o
);
    logic                       miss_go;
    upd_t                       upd;
    wmask_t                     rd_valid;
    logic [WAYS-1:0][CNT_W-1:0] rd_local;
    logic [CNT_W-1:0]           rd_glob;
    logic [15:0]                rnd;
    way_t                       pick;
    wmask_t                     tie;
    logic                       vld_q;
    way_t                       way_q;

    assign miss_go = miss_i & ~hit_i;

    always_comb begin
        upd.op  = OP_IDLE;
        upd.way = pick;
        if (hit_i) begin
            upd.op  = OP_HIT;
            upd.way = hit_way_i;
        end else if (miss_i) begin
            upd.op  = OP_FILL;
        end
    end

    rvs_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .rnd_o (rnd)
    );

    rvs_set_store #(.NUM_SETS(NUM_SETS), .CNT_W(CNT_W), .SET_W(SET_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_i),
        .upd_i      (upd),
        .rd_valid_o (rd_valid),
        .rd_local_o (rd_local),
        .rd_glob_o  (rd_glob)
    );

    rvs_pick #(.CNT_W(CNT_W)) u_pick (
        .valid_i (rd_valid),
        .local_i (rd_local),
        .rnd_i   (rnd[7:0]),
        .pick_o  (pick),
        .tie_o   (tie)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            way_q <= '0;
        end else begin
            vld_q <= miss_go;
            if (miss_go) way_q <= pick;
        end
    end

    assign victim_valid_o = vld_q;
    assign victim_way_o   = way_q;

    AST_PULSE_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
        miss_go |=> victim_valid_o); // R3
    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!miss_i || hit_i) |=> !victim_valid_o); // R9
    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (miss_go && !(&rd_valid)) |-> !rd_valid[pick]); // R2
    AST_TIE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (miss_go && (&rd_valid)) |-> tie[pick]); // R5
    for (genvar w = 0; w < WAYS; w++) begin : g_min
        AST_MIN_CHOSEN: assert property (@(posedge clk) disable iff (rst)
            (miss_go && (&rd_valid)) |-> (rd_local[pick] <= rd_local[w])); // R4
    end
endmodule

// File: tb/rate_victim_select_test.sv
module rate_victim_select_test;
    localparam int CLK_NS = 10;
    localparam int NS     = 4;
    localparam int CW     = 4;
    localparam int CMAX   = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] set_i;
    logic       hit_i;
    logic [1:0] hit_way_i;
    logic       miss_i;
    logic       victim_valid_o;
    logic [1:0] victim_way_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int ml [NS][4];
    int mg [NS];
    bit mv [NS][4];

    always #(CLK_NS/2) clk = ~clk;

    rate_victim_select #(.NUM_SETS(NS), .CNT_W(CW)) uut (
        .clk            (clk),
        .rst            (rst),
        .set_i          (set_i),
        .hit_i          (hit_i),
        .hit_way_i      (hit_way_i),
        .miss_i         (miss_i),
        .victim_valid_o (victim_valid_o),
        .victim_way_o   (victim_way_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_step(input int s, input bit is_hit, input int w);
        if (mg[s] == CMAX) begin
            mg[s] = mg[s] / 2;
            for (int i = 0; i < 4; i++) ml[s][i] = ml[s][i] / 2;
        end
        mg[s]++;
        if (is_hit) begin
            if (ml[s][w] < CMAX) ml[s][w]++;
        end else begin
            ml[s][w] = 0;
            mv[s][w] = 1'b1;
        end
    endfunction

    function automatic logic [3:0] exp_mask(input int s);
        int mn;
        logic [3:0] m;
        for (int i = 0; i < 4; i++) if (!mv[s][i]) return 4'(1 << i);
        mn = ml[s][0];
        for (int i = 1; i < 4; i++) if (ml[s][i] < mn) mn = ml[s][i];
        m = '0;
        for (int i = 0; i < 4; i++) m[i] = (ml[s][i] == mn);
        return m;
    endfunction

    task automatic do_hit(input int s, input int w);
        @(negedge clk);
        set_i = 2'(s); hit_i = 1'b1; hit_way_i = 2'(w); miss_i = 1'b0;
        @(posedge clk); #1;
        model_step(s, 1'b1, w);
        check(victim_valid_o == 1'b0, "R3 no strobe after hit", int'(victim_valid_o), 0);
    endtask

    task automatic do_both(input int s, input int w);
        @(negedge clk);
        set_i = 2'(s); hit_i = 1'b1; hit_way_i = 2'(w); miss_i = 1'b1;
        @(posedge clk); #1;
        model_step(s, 1'b1, w);
        check(victim_valid_o == 1'b0, "R9 miss ignored with hit", int'(victim_valid_o), 0);
    endtask

    task automatic do_miss(input int s, input string req, output int got);
        logic [3:0] em;
        @(negedge clk);
        set_i = 2'(s); hit_i = 1'b0; hit_way_i = 2'd0; miss_i = 1'b1;
        em = exp_mask(s);
        @(posedge clk); #1;
        check(victim_valid_o == 1'b1, "R3 strobe after miss", int'(victim_valid_o), 1);
        got = int'(victim_way_o);
        check(em[got] == 1'b1, req, got, int'(em));
        model_step(s, 1'b0, got);
    endtask

    task automatic do_idle();
        @(negedge clk);
        hit_i = 1'b0; miss_i = 1'b0;
        @(posedge clk); #1;
        check(victim_valid_o == 1'b0, "R3 strobe one cycle", int'(victim_valid_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int got;
        logic [3:0] seen;
        rst = 1'b1; set_i = '0; hit_i = 1'b0; hit_way_i = '0; miss_i = 1'b0;
        for (int s = 0; s < NS; s++) begin
            mg[s] = 0;
            for (int w = 0; w < 4; w++) begin ml[s][w] = 0; mv[s][w] = 1'b0; end
        end
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 check(victim_valid_o == 1'b0, "R1 strobe low in reset", int'(victim_valid_o), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(victim_valid_o == 1'b0, "R1 strobe low after reset", int'(victim_valid_o), 0);

        // R2: empty ways filled in order
        for (int k = 0; k < 4; k++) begin
            do_miss(0, "R2 lowest empty way", got);
            check(got == k, "R2 fill order", got, k);
        end
        do_idle();

        // R4: unique minimum count chosen
        do_hit(0, 0); do_hit(0, 0);
        for (int k = 0; k < 3; k++) do_hit(0, 1);
        for (int k = 0; k < 4; k++) do_hit(0, 2);
        do_hit(0, 3);
        do_miss(0, "R4 min count", got);
        check(got == 3, "R4 unique min way", got, 3);
        // R6 + R8: refilled way at 0, global at maximum, halved first
        do_miss(0, "R6 refilled way", got);
        check(got == 3, "R6 count cleared on fill", got, 3);
        check(mg[0] == 8, "R8 model halved", mg[0], 8);
        for (int k = 0; k < 20; k++) do_hit(0, k % 3);
        do_miss(0, "R8 after halving", got);
        do_idle();

        // R7: set isolation
        for (int k = 0; k < 4; k++) do_miss(1, "R2 fill set1", got);
        do_hit(1, 0); do_hit(1, 1); do_hit(1, 2);
        for (int k = 0; k < 10; k++) do_hit(0, 3);
        do_miss(1, "R7 other set untouched", got);
        check(got == 3, "R7 set isolation", got, 3);

        // R9: hit and miss together
        do_both(1, 3);
        do_miss(1, "R9 state after hit only", got);

        // R5: ties spread
        for (int k = 0; k < 4; k++) do_miss(3, "R2 fill set3", got);
        seen = '0;
        for (int k = 0; k < 40; k++) begin
            do_miss(3, "R5 tie member", got);
            seen[got] = 1'b1;
        end
        check($countones(seen) >= 2, "R5 tie spread", $countones(seen), 2);
        do_idle();

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            int r, s;
            r = $urandom_range(0, 9);
            s = $urandom_range(0, NS - 1);
            if (r < 6)      do_hit(s, $urandom_range(0, 3));
            else if (r < 9) do_miss(s, "R4 random victim", got);
            else            do_both(s, $urandom_range(0, 3));
        end
        do_idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule